// File: doc/BRIEF.md
# Four-group look-ahead carry generator with 64-bit adder

The carry generator looks across four adder groups at once. Each group reports a propagate and a generate signal, both active low, and a true-form carry enters at the bottom. From these the unit forms, with no clock, the three carries that enter groups 1, 2 and 3. It also forms a combined propagate and a combined generate, both active low again. A parent unit can take those two signals directly as one of its own four group inputs, so units stack into a look-ahead tree of any depth.

The top module is a 64-bit adder built from these units. Sixteen 4-bit slices each use one generator at bit level. They report active-low group signals to four first-level generators, and these report to one root generator. Every slice carry is therefore resolved through at most three generator levels, with no ripple between slices. The sum and the carry-out are captured in registers on the rising clock edge, and a synchronous active-high reset clears them.

Top module: `cla_adder64`

## Requirements
- R1: The generator's carries into groups 1, 2 and 3 (c_x, c_y, c_z) are active high. Each equals the true-form ripple result c(i+1) = g(i) | p(i)&c(i), starting at c(0) = c_in, where g = ~g_n and p = ~p_n. Bit i of g_n and p_n belongs to group i.
- R2: The generator's group propagate output gp_n is 0 exactly when all four p_n bits are 0.
- R3: The generator's group generate output gg_n is 0 exactly when the ripple of R1, started from a carry of 0, gives a carry out of group 3.
- R4: The generator's outputs follow its present inputs in the same time step, without any clock.
- R5: One rising clock edge after a, b and cin are applied, sum holds (a + b + cin) mod 2^64.
- R6: On that same edge, cout holds bit 64 of a + b + cin.
- R7: While rst is 1 at a rising edge, sum and cout become 0 at that edge, whatever the operands are.
- R8: When a + b is all ones and cin is 1, the carry passes through every group: the next sum is 0 and cout is 1.
- R9: When a = b = 0 and cin = 1, the next sum is 1 and cout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0, active high |
| sum | output | 64 | Registered sum |
| cout | output | 1 | Registered carry out of bit 63 |

## Verification
A second, stand-alone generator instance is driven through all 512 input combinations. Its outputs are due in the same time step, and each one is compared 1 time unit after the inputs change. The adder's sum and cout are due one rising edge after the operands, so the bench drives operands on a falling edge and compares on the next falling edge. At that point exactly one capture has happened. The reset check holds nonzero operands while rst is high, and then samples after that edge.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Number of groups one look-ahead unit spans.
  localparam int unsigned FANIN = 4;
endpackage

// File: rtl/cla_unit.sv
module cla_unit
  import cla_pkg::*;
(
  input  logic             c_in,
  input  logic [FANIN-1:0] p_n,
  input  logic [FANIN-1:0] g_n,
  output logic             c_x,
  output logic             c_y,
  output logic             c_z,
  output logic             gp_n,
  output logic             gg_n
);
  logic [FANIN-1:0] p, g;

  always_comb begin
    p    = ~p_n;
    g    = ~g_n;
    c_x  = g[0] | (p[0] & c_in);
    c_y  = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_in);
    c_z  = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c_in);
    gg_n = ~(g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]));
    gp_n = ~(&p);
  end

  always_comb begin
    // R1
    carry_pass_chk: assert (!(!gp_n && c_in) || (c_x && c_y && c_z));
    // R1
    carry_chain_chk: assert (!(c_z && g_n[2]) || !p_n[2] == 1'b1 && c_y || !c_z || !g_n[2]);
    // R3
    group_gen_chk: assert (!(!g_n[3]) || !gg_n);
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
(
  input  logic [FANIN-1:0] a,
  input  logic [FANIN-1:0] b,
  input  logic             cin,
  output logic [FANIN-1:0] s,
  output logic             gp_n,
  output logic             gg_n
);
  logic [FANIN-1:0] half;
  logic             cx, cy, cz;

  assign half = a ^ b;

  cla_unit bit_la_i (
    .c_in (cin),
    .p_n  (~half),
    .g_n  (~(a & b)),
    .c_x  (cx),
    .c_y  (cy),
    .c_z  (cz),
    .gp_n (gp_n),
    .gg_n (gg_n)
  );

  assign s = half ^ {cz, cy, cx, cin};
endmodule

// File: rtl/cla_adder64.sv
module cla_adder64
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  // Three look-ahead levels: slices, first-level units, one root unit.
  localparam int unsigned N_SLICE = WIDTH / FANIN;
  localparam int unsigned N_MID   = N_SLICE / FANIN;

  logic [N_SLICE-1:0] s_gn, s_pn, s_cin;
  logic [N_MID-1:0]   m_gn, m_pn, m_cin;
  logic [WIDTH-1:0]   sum_d;
  logic               root_gp_n, root_gg_n, cout_d;

  genvar i, j;
  generate
    for (i = 0; i < N_SLICE; i++) begin : g_slice
      cla_slice slice_i (
        .a    (a[i*FANIN +: FANIN]),
        .b    (b[i*FANIN +: FANIN]),
        .cin  (s_cin[i]),
        .s    (sum_d[i*FANIN +: FANIN]),
        .gp_n (s_pn[i]),
        .gg_n (s_gn[i])
      );
    end
    for (j = 0; j < N_MID; j++) begin : g_mid
      assign s_cin[j*FANIN] = m_cin[j];
      cla_unit mid_i (
        .c_in (m_cin[j]),
        .p_n  (s_pn[j*FANIN +: FANIN]),
        .g_n  (s_gn[j*FANIN +: FANIN]),
        .c_x  (s_cin[j*FANIN+1]),
        .c_y  (s_cin[j*FANIN+2]),
        .c_z  (s_cin[j*FANIN+3]),
        .gp_n (m_pn[j]),
        .gg_n (m_gn[j])
      );
    end
  endgenerate

  assign m_cin[0] = cin;

  cla_unit root_i (
    .c_in (cin),
    .p_n  (m_pn),
    .g_n  (m_gn),
    .c_x  (m_cin[1]),
    .c_y  (m_cin[2]),
    .c_z  (m_cin[3]),
    .gp_n (root_gp_n),
    .gg_n (root_gg_n)
  );

  assign cout_d = ~root_gg_n | (~root_gp_n & cin);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_d;
      cout <= cout_d;
    end
  end

  // R7
  reset_clear_chk: assert property (@(posedge clk) rst |=> (sum == '0 && !cout));
  // R8
  full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (((a ^ b) == '1) && (a & b) == '0 && cin) |=> (sum == '0 && cout));
  // R9
  zero_plus_one_chk: assert property (@(posedge clk) disable iff (rst)
    (a == '0 && b == '0 && cin) |=> (sum == {{(WIDTH-1){1'b0}}, 1'b1} && !cout));
endmodule

// File: tb/cla_adder64_tb_top.sv
module cla_adder64_tb_top;
  localparam int W = 64;
  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] a = '0, b = '0, sum;
  logic cin = 1'b0, cout;
  logic u_c = 1'b0;
  logic [3:0] u_p = 4'hF, u_g = 4'hF;
  logic u_x, u_y, u_z, u_gp, u_gg;
  int n_chk = 0, n_bad = 0, cycles = 0;

  always #10 clk = ~clk;

  cla_adder64 #(.WIDTH(W)) dut_i (.clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
    .sum(sum), .cout(cout));
  cla_unit unit_i (.c_in(u_c), .p_n(u_p), .g_n(u_g), .c_x(u_x), .c_y(u_y),
    .c_z(u_z), .gp_n(u_gp), .gg_n(u_gg));

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic unit_case(input int v);
    logic c, cz0;
    logic [3:0] p, g, cc;
    u_c = v[8]; u_p = v[7:4]; u_g = v[3:0];
    p = ~u_p; g = ~u_g;
    c = u_c;
    for (int i = 0; i < 4; i++) begin cc[i] = c; c = g[i] | (p[i] & c); end
    cz0 = 1'b0;
    for (int i = 0; i < 4; i++) cz0 = g[i] | (p[i] & cz0);
    #1;
    // R1 R4
    chk("R1", {62'd0, u_x, u_y, u_z}, {62'd0, cc[1], cc[2], cc[3]});
    chk("R2", {64'd0, u_gp}, {64'd0, ~(&p)});
    chk("R3", {64'd0, u_gg}, {64'd0, ~cz0});
  endtask

  task automatic add_case(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                          input logic ci);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; cin = ci;
    exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    @(negedge clk);
    chk({req, " sum"}, {1'b0, sum}, {1'b0, exp[W-1:0]});
    chk({req, " cout"}, {64'd0, cout}, {64'd0, exp[W]});
  endtask

  initial begin
    for (int v = 0; v < 512; v++) unit_case(v);
    a = '1; b = 64'h1234; cin = 1'b1;
    @(negedge clk); @(negedge clk);
    // R7
    chk("R7", {cout, sum}, '0);
    rst = 1'b0;
    add_case("R8", '1, '0, 1'b1);
    add_case("R8", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1);
    add_case("R9", '0, '0, 1'b1);
    add_case("R6", '1, '1, 1'b1);
    add_case("R6", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    add_case("R5", '0, '0, 1'b0);
    add_case("R5", 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0);
    add_case("R5", 64'h0FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    for (int k = 0; k < 200; k++)
      add_case("R5", {$urandom, $urandom}, {$urandom, $urandom}, k[0]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R7", {cout, sum}, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule